// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block holds the hazard logic for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) in which branches are resolved in decode. It is purely combinational. In each cycle it looks at the register specifiers and control flags held in the stage registers. It returns bypass selects for the two ALU operands in execute and for the two equality-comparator operands in decode. It also returns one hazard signal, driven on three outputs, that freezes fetch and decode and clears the execute stage register.

The surrounding datapath owns the bypass muxes, the pipeline registers and the register file. It wires the selects and stall lines produced here straight into them. A select of 2'b10 picks the memory-stage result, 2'b01 picks the writeback result, and 2'b00 keeps the register-file value.

Top module: `hazard_ctl`

## Requirements
- R1: `exe_fwd_a` is 2'b10 whenever `exe_rs` is nonzero, equals `mem_dst`, and `mem_wr` is 1. This holds whatever the writeback stage holds.
- R2: When R1 does not apply, `exe_fwd_a` is 2'b01 if `exe_rs` is nonzero, equals `wb_dst`, and `wb_wr` is 1.
- R3: In every other case `exe_fwd_a` is 2'b00. A specifier of register 0 never yields a nonzero select on any bypass output.
- R4: `exe_fwd_b` obeys R1 to R3 with `exe_rt` in place of `exe_rs`.
- R5: `dec_fwd_a` is 1 exactly when `dec_rs` is nonzero, equals `mem_dst`, and `mem_wr` is 1. `dec_fwd_b` follows the same rule with `dec_rt`. A writeback-stage match alone never sets either output.
- R6: A load-use hazard is raised when `exe_load` is 1 and `dec_rs` or `dec_rt` equals `exe_rt`.
- R7: A branch hazard is raised when `dec_branch` and `exe_wr` are both 1 and `exe_dst` equals `dec_rs` or `dec_rt`.
- R8: A branch hazard is raised when `dec_branch` and `mem_load` are both 1 and `mem_dst` equals `dec_rs` or `dec_rt`.
- R9: `stall_fetch`, `stall_decode` and `flush_exec` are always equal, and are 1 exactly when R6, R7 or R8 raises a hazard.
- R10: The bypass selects depend only on the specifiers and write flags. Their values are the same whether or not a hazard is raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs | input | 5 | First source specifier in decode |
| dec_rt | input | 5 | Second source specifier in decode |
| exe_rs | input | 5 | First source specifier in execute |
| exe_rt | input | 5 | Second source specifier in execute (also the load target) |
| exe_dst | input | 5 | Destination specifier in execute |
| mem_dst | input | 5 | Destination specifier in memory |
| wb_dst | input | 5 | Destination specifier in writeback |
| exe_wr | input | 1 | Execute-stage instruction writes a register |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| exe_load | input | 1 | Execute-stage instruction is a load |
| mem_load | input | 1 | Memory-stage instruction is a load |
| dec_branch | input | 1 | Decode-stage instruction is a branch |
| exe_fwd_a | output | 2 | Bypass select, execute operand A |
| exe_fwd_b | output | 2 | Bypass select, execute operand B |
| dec_fwd_a | output | 1 | Bypass select, decode comparator operand A |
| dec_fwd_b | output | 1 | Bypass select, decode comparator operand B |
| stall_fetch | output | 1 | Hold the fetch stage |
| stall_decode | output | 1 | Hold the decode stage |
| flush_exec | output | 1 | Clear the execute stage register |

## Verification
Bypassing and stalling can occur in the same cycle. One case is a load waiting in execute while an older ALU result still needs bypassing into execute. Another is a branch in decode waiting on a load in memory while the decode comparator bypasses from that same stage. Directed vectors build both cases. They check that the hazard lines rise and that the bypass selects still hold the values R1 to R5 give. A random sweep over a narrow specifier range then produces many more such overlaps, and a reference model written from the requirements judges each one.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

   // Bypass select encoding shared by the execute-stage operand muxes.
   typedef enum logic [1:0] {
      BYP_REGFILE = 2'b00,
      BYP_WBACK   = 2'b01,
      BYP_MEMORY  = 2'b10
   } byp_sel_e;

   localparam int unsigned EXE_OPERANDS = 2;
   localparam int unsigned DEC_OPERANDS = 2;

endpackage

// File: rtl/hz_match.sv
module hz_match #(
   parameter int unsigned REG_W         = 5,
   parameter bit          ZERO_IS_CONST = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] dst,
   input  logic             wr,
   output logic             hit
);

   localparam logic [REG_W-1:0] ZERO_SPEC = '0;

   generate
      if (ZERO_IS_CONST) begin : g_guard_zero
         // Register 0 always reads as zero, so a write to it is never bypassed.
         assign hit = wr && (src != ZERO_SPEC) && (src == dst);
      end else begin : g_plain
         assign hit = wr && (src == dst);
      end
   endgenerate

endmodule

// File: rtl/hz_exec_fwd.sv
module hz_exec_fwd #(
   parameter int unsigned REG_W         = 5,
   parameter bit          ZERO_IS_CONST = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] mem_dst,
   input  logic [REG_W-1:0] wb_dst,
   input  logic             mem_wr,
   input  logic             wb_wr,
   output logic [1:0]       sel
);
   import hazard_pkg::*;

   logic hit_mem;
   logic hit_wb;

   hz_match #(.REG_W(REG_W), .ZERO_IS_CONST(ZERO_IS_CONST)) u_mem (
      .src(src), .dst(mem_dst), .wr(mem_wr), .hit(hit_mem)
   );
   hz_match #(.REG_W(REG_W), .ZERO_IS_CONST(ZERO_IS_CONST)) u_wb (
      .src(src), .dst(wb_dst), .wr(wb_wr), .hit(hit_wb)
   );

   // The younger result, in the memory stage, wins over writeback.
   always_comb begin
      if (hit_mem)     sel = BYP_MEMORY;
      else if (hit_wb) sel = BYP_WBACK;
      else             sel = BYP_REGFILE;
   end

endmodule

// File: rtl/hz_stall.sv
module hz_stall #(
   parameter int unsigned REG_W = 5
) (
   input  logic [REG_W-1:0] dec_rs,
   input  logic [REG_W-1:0] dec_rt,
   input  logic [REG_W-1:0] exe_rt,
   input  logic [REG_W-1:0] exe_dst,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             exe_wr,
   input  logic             exe_load,
   input  logic             mem_load,
   input  logic             dec_branch,
   output logic             hazard
);

   logic load_use;
   logic br_on_exe;
   logic br_on_mem;

   // A load's data exists only after the memory stage; a decode consumer waits.
   assign load_use  = exe_load && ((dec_rs == exe_rt) || (dec_rt == exe_rt));
   // The decode comparator cannot take an ALU result still in execute.
   assign br_on_exe = dec_branch && exe_wr &&
                      ((exe_dst == dec_rs) || (exe_dst == dec_rt));
   // Nor a load result that is still being read in the memory stage.
   assign br_on_mem = dec_branch && mem_load &&
                      ((mem_dst == dec_rs) || (mem_dst == dec_rt));

   assign hazard = load_use || br_on_exe || br_on_mem;

endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
   parameter int unsigned REG_W         = 5,
   parameter bit          ZERO_IS_CONST = 1'b1
) (
   input  logic [REG_W-1:0] dec_rs,
   input  logic [REG_W-1:0] dec_rt,
   input  logic [REG_W-1:0] exe_rs,
   input  logic [REG_W-1:0] exe_rt,
   input  logic [REG_W-1:0] exe_dst,
   input  logic [REG_W-1:0] mem_dst,
   input  logic [REG_W-1:0] wb_dst,
   input  logic             exe_wr,
   input  logic             mem_wr,
   input  logic             wb_wr,
   input  logic             exe_load,
   input  logic             mem_load,
   input  logic             dec_branch,
   output logic [1:0]       exe_fwd_a,
   output logic [1:0]       exe_fwd_b,
   output logic             dec_fwd_a,
   output logic             dec_fwd_b,
   output logic             stall_fetch,
   output logic             stall_decode,
   output logic             flush_exec
);
   import hazard_pkg::*;

   generate
      if (REG_W < 2 || REG_W > 8) begin : g_bad_width
         $error("hazard_ctl: REG_W must lie in 2..8");
      end
   endgenerate

   logic [REG_W-1:0] exe_src [EXE_OPERANDS];
   logic [1:0]       exe_sel [EXE_OPERANDS];
   logic [REG_W-1:0] dec_src [DEC_OPERANDS];
   logic             dec_sel [DEC_OPERANDS];
   logic             hazard;

   assign exe_src[0] = exe_rs;
   assign exe_src[1] = exe_rt;
   assign dec_src[0] = dec_rs;
   assign dec_src[1] = dec_rt;

   genvar gi;
   generate
      for (gi = 0; gi < EXE_OPERANDS; gi++) begin : g_exe
         hz_exec_fwd #(.REG_W(REG_W), .ZERO_IS_CONST(ZERO_IS_CONST)) u_fwd (
            .src    (exe_src[gi]),
            .mem_dst(mem_dst),
            .wb_dst (wb_dst),
            .mem_wr (mem_wr),
            .wb_wr  (wb_wr),
            .sel    (exe_sel[gi])
         );
      end
      // Decode bypass draws only from the memory stage; writeback data
      // reaches decode through the register file's write-before-read.
      for (gi = 0; gi < DEC_OPERANDS; gi++) begin : g_dec
         hz_match #(.REG_W(REG_W), .ZERO_IS_CONST(ZERO_IS_CONST)) u_cmp (
            .src(dec_src[gi]), .dst(mem_dst), .wr(mem_wr), .hit(dec_sel[gi])
         );
      end
   endgenerate

   hz_stall #(.REG_W(REG_W)) u_stall (
      .dec_rs    (dec_rs),
      .dec_rt    (dec_rt),
      .exe_rt    (exe_rt),
      .exe_dst   (exe_dst),
      .mem_dst   (mem_dst),
      .exe_wr    (exe_wr),
      .exe_load  (exe_load),
      .mem_load  (mem_load),
      .dec_branch(dec_branch),
      .hazard    (hazard)
   );

   assign exe_fwd_a    = exe_sel[0];
   assign exe_fwd_b    = exe_sel[1];
   assign dec_fwd_a    = dec_sel[0];
   assign dec_fwd_b    = dec_sel[1];
   assign stall_fetch  = hazard;
   assign stall_decode = hazard;
   assign flush_exec   = hazard;

endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
   parameter int unsigned REG_W = 5
) (
   input logic [REG_W-1:0] dec_rs,
   input logic [REG_W-1:0] dec_rt,
   input logic [REG_W-1:0] exe_rs,
   input logic [REG_W-1:0] exe_rt,
   input logic [REG_W-1:0] exe_dst,
   input logic [REG_W-1:0] mem_dst,
   input logic [REG_W-1:0] wb_dst,
   input logic             exe_wr,
   input logic             mem_wr,
   input logic             wb_wr,
   input logic             exe_load,
   input logic             mem_load,
   input logic             dec_branch,
   input logic [1:0]       exe_fwd_a,
   input logic [1:0]       exe_fwd_b,
   input logic             dec_fwd_a,
   input logic             dec_fwd_b,
   input logic             stall_fetch,
   input logic             stall_decode,
   input logic             flush_exec
);

   localparam logic [REG_W-1:0] Z = '0;

   always_comb begin
      // R1: a live memory-stage match selects the memory result
      if (mem_wr && exe_rs != Z && exe_rs == mem_dst)
         a_r1_mem_wins: assert (exe_fwd_a == 2'b10);
      // R3: register 0 is never bypassed
      if (exe_rs == Z)
         a_r3_zero_a: assert (exe_fwd_a == 2'b00);
      if (dec_rt == Z)
         a_r3_zero_dec: assert (!dec_fwd_b);
      // R4: operand B never takes the unused code
      a_r4_b_legal: assert (exe_fwd_b != 2'b11);
      // R5: decode bypass exists only with a writing memory stage
      if (dec_fwd_a || dec_fwd_b)
         a_r5_mem_only: assert (mem_wr);
      // R6: load-use forces the hold
      if (exe_load && (dec_rs == exe_rt || dec_rt == exe_rt))
         a_r6_load_use: assert (stall_fetch);
      // R7: branch behind an ALU writer in execute forces the hold
      if (dec_branch && exe_wr && (exe_dst == dec_rs || exe_dst == dec_rt))
         a_r7_br_exe: assert (stall_decode);
      // R9: the three hazard lines agree
      a_r9_lines_agree: assert (stall_fetch == stall_decode && stall_decode == flush_exec);
   end

endmodule

bind hazard_ctl hazard_ctl_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/hazard_ctl_bench.sv
module hazard_ctl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int RW         = 5;
   localparam int N_RANDOM   = 3000;
   localparam int WATCHDOG   = 20000;

   typedef struct packed {
      logic [4:0] d_rs, d_rt, e_rs, e_rt, e_dst, m_dst, w_dst;
      logic       e_wr, m_wr, w_wr, e_ld, m_ld, br;
      logic [1:0] x_fa, x_fb;
      logic       x_da, x_db, x_st;
   } vec_t;

   localparam int N_VEC = 11;
   localparam vec_t VEC [N_VEC] = '{
      //  drs   drt   ers   ert   edst  mdst  wdst  ew mw ww el ml br | fa     fb     da db st
      '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 0},
      '{5'd0, 5'd0, 5'd3, 5'd0, 5'd0, 5'd3, 5'd3, 0, 1, 1, 0, 0, 0, 2'b10, 2'b00, 0, 0, 0},
      '{5'd0, 5'd0, 5'd4, 5'd5, 5'd0, 5'd5, 5'd4, 0, 1, 1, 0, 0, 0, 2'b01, 2'b10, 0, 0, 0},
      '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 0, 1, 1, 0, 0, 0, 2'b00, 2'b00, 0, 0, 0},
      '{5'd0, 5'd0, 5'd7, 5'd0, 5'd0, 5'd7, 5'd7, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 0},
      '{5'd2, 5'd9, 5'd0, 5'd9, 5'd0, 5'd0, 5'd0, 0, 0, 0, 1, 0, 0, 2'b00, 2'b00, 0, 0, 1},
      '{5'd6, 5'd1, 5'd0, 5'd0, 5'd6, 5'd0, 5'd0, 1, 0, 0, 0, 0, 1, 2'b00, 2'b00, 0, 0, 1},
      '{5'd1, 5'd8, 5'd0, 5'd0, 5'd0, 5'd8, 5'd0, 0, 1, 0, 0, 1, 1, 2'b00, 2'b00, 0, 1, 1},
      '{5'd10,5'd11,5'd0, 5'd0, 5'd0, 5'd11,5'd10,0, 1, 1, 0, 0, 0, 2'b00, 2'b00, 0, 1, 0},
      '{5'd13,5'd0, 5'd12,5'd13,5'd0, 5'd12,5'd0, 0, 1, 0, 1, 0, 0, 2'b10, 2'b00, 0, 0, 1},
      '{5'd6, 5'd0, 5'd0, 5'd0, 5'd6, 5'd0, 5'd0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00, 0, 0, 0}
   };

   logic          clk = 1'b0;
   logic [RW-1:0] dec_rs, dec_rt, exe_rs, exe_rt, exe_dst, mem_dst, wb_dst;
   logic          exe_wr, mem_wr, wb_wr, exe_load, mem_load, dec_branch;
   logic [1:0]    exe_fwd_a, exe_fwd_b;
   logic          dec_fwd_a, dec_fwd_b, stall_fetch, stall_decode, flush_exec;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hazard_ctl #(.REG_W(RW)) u_hazard_ctl (
      .dec_rs(dec_rs), .dec_rt(dec_rt), .exe_rs(exe_rs), .exe_rt(exe_rt),
      .exe_dst(exe_dst), .mem_dst(mem_dst), .wb_dst(wb_dst),
      .exe_wr(exe_wr), .mem_wr(mem_wr), .wb_wr(wb_wr),
      .exe_load(exe_load), .mem_load(mem_load), .dec_branch(dec_branch),
      .exe_fwd_a(exe_fwd_a), .exe_fwd_b(exe_fwd_b),
      .dec_fwd_a(dec_fwd_a), .dec_fwd_b(dec_fwd_b),
      .stall_fetch(stall_fetch), .stall_decode(stall_decode), .flush_exec(flush_exec)
   );

   task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      @(posedge clk);
      dec_rs = v.d_rs; dec_rt = v.d_rt; exe_rs = v.e_rs; exe_rt = v.e_rt;
      exe_dst = v.e_dst; mem_dst = v.m_dst; wb_dst = v.w_dst;
      exe_wr = v.e_wr; mem_wr = v.m_wr; wb_wr = v.w_wr;
      exe_load = v.e_ld; mem_load = v.m_ld; dec_branch = v.br;
      @(negedge clk);
   endtask

   // Reference written from the requirements.
   function automatic logic [1:0] ref_exe(input logic [4:0] s, input vec_t v);
      if (v.m_wr && s != 0 && s == v.m_dst)      return 2'b10;  // R1
      else if (v.w_wr && s != 0 && s == v.w_dst) return 2'b01;  // R2
      else                                       return 2'b00;  // R3
   endfunction

   function automatic vec_t with_expect(input vec_t v);
      vec_t r = v;
      logic lu, be, bm;
      r.x_fa = ref_exe(v.e_rs, v);
      r.x_fb = ref_exe(v.e_rt, v);                                  // R4
      r.x_da = v.m_wr && v.d_rs != 0 && v.d_rs == v.m_dst;          // R5
      r.x_db = v.m_wr && v.d_rt != 0 && v.d_rt == v.m_dst;
      lu = v.e_ld && (v.d_rs == v.e_rt || v.d_rt == v.e_rt);        // R6
      be = v.br && v.e_wr && (v.e_dst == v.d_rs || v.e_dst == v.d_rt); // R7
      bm = v.br && v.m_ld && (v.m_dst == v.d_rs || v.m_dst == v.d_rt); // R8
      r.x_st = lu || be || bm;
      return r;
   endfunction

   task automatic compare(input vec_t v, input string ctx);
      check({ctx, " R1/R2/R3 exe_fwd_a"}, exe_fwd_a, v.x_fa);
      check({ctx, " R4 exe_fwd_b"}, exe_fwd_b, v.x_fb);
      check({ctx, " R5 dec_fwd_a"}, {1'b0, dec_fwd_a}, {1'b0, v.x_da});
      check({ctx, " R5 dec_fwd_b"}, {1'b0, dec_fwd_b}, {1'b0, v.x_db});
      check({ctx, " R9 stall_fetch"}, {1'b0, stall_fetch}, {1'b0, v.x_st});
      check({ctx, " R9 stall_decode"}, {1'b0, stall_decode}, {1'b0, v.x_st});
      check({ctx, " R9 flush_exec"}, {1'b0, flush_exec}, {1'b0, v.x_st});
   endtask

   initial begin
      vec_t v;
      // Table walk: idle state, R1, R2, R3 (zero and no write), R6, R7,
      // R8 with R5 bypass, R5 without writeback bypass, R10 overlap, no-writer branch.
      for (int i = 0; i < N_VEC; i++) begin
         drive(VEC[i]);
         compare(VEC[i], $sformatf("vec%0d", i));
      end

      // R10: identical specifiers with and without a load in execute
      v = VEC[1];
      v.e_ld = 1'b1; v.e_rt = 5'd0; v.d_rs = 5'd0;
      v = with_expect(v);
      drive(v);
      check("R10 select kept under hazard", exe_fwd_a, 2'b10);
      check("R10 hazard raised", {1'b0, stall_fetch}, 2'b01);

      // R8 alone: load in memory without write flag still stalls a branch
      v = '0;
      v.br = 1'b1; v.m_ld = 1'b1; v.m_dst = 5'd14; v.d_rs = 5'd14;
      v = with_expect(v);
      drive(v);
      check("R8 branch on memory load", {1'b0, flush_exec}, 2'b01);
      check("R5 no bypass without mem_wr", {1'b0, dec_fwd_a}, 2'b00);

      // Random sweep over a narrow specifier range for frequent matches
      for (int n = 0; n < N_RANDOM; n++) begin
         v = '0;
         v.d_rs = 5'($urandom_range(0, 3)); v.d_rt = 5'($urandom_range(0, 3));
         v.e_rs = 5'($urandom_range(0, 3)); v.e_rt = 5'($urandom_range(0, 3));
         v.e_dst = 5'($urandom_range(0, 3)); v.m_dst = 5'($urandom_range(0, 3));
         v.w_dst = 5'($urandom_range(0, 3));
         v.e_wr = 1'($urandom); v.m_wr = 1'($urandom); v.w_wr = 1'($urandom);
         v.e_ld = 1'($urandom); v.m_ld = 1'($urandom); v.br = 1'($urandom);
         v = with_expect(v);
         drive(v);
         compare(v, "rand");
      end
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      end
      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule